// File: doc/BRIEF.md
# Wakeup-Aware System Clock Controller

This block picks which of four oscillator clocks drives the CPU/bus clock, divides it by 1, 2, 4 or 8, and drives the enable lines of those oscillators. Control fields arrive in register style: a write strobe loads a source, a ratio and a set of oscillator enable bits together. A change of source or ratio runs a break-before-make sequence. The old clock is gated off on its own falling edge. The divider is cleared while no clock passes. The new clock is gated on only after its own two-flop synchroniser shows that it is toggling.

A sleep request parks the controller and stops the oscillators named in a stop mask. A wakeup event ends sleep in one of two ways. In the first, the source and ratio in use before sleep are kept. In the second, a preset wakeup source and ratio are loaded; the wakeup source's oscillator is forced on and the reported fields follow the new clock. Independently of that choice, the oscillator enable bits are either restored or replaced by a preset set at wakeup. The control logic runs on an always-on register clock. The oscillators are free-running inputs, each of which toggles only while its enable line is high.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset, `cur_src` is 0 (the fast internal boot oscillator), `cur_div` is 0 and `osc_en` is 4'b0001. Once `switch_done` rises, `sys_clk` has the period of source 0 undivided.
- R2: Source codes are 0 = fast internal oscillator, 1 = fast crystal/ceramic oscillator, 2 = external clock input, 3 = low-speed oscillator. A write while `switch_done` is high, to an enabled source or a new ratio, drops `switch_done` and raises it again once `sys_clk` runs from that source. At that point `cur_src` and `cur_div` show the values written.
- R3: Ratio codes 0, 1, 2 and 3 divide the selected source by 1, 2, 4 and 8.
- R4: Switching is break-before-make. At most one source is ever gated into the clock path. After `switch_done` rises, every `sys_clk` period matches the new source and ratio.
- R5: A write whose source has its own enable bit at 0 in the written enable set leaves `cur_src`, `cur_div`, `switch_done` and the `sys_clk` period unchanged. The enable bits are still taken.
- R6: Outside sleep, bit i of `osc_en` (bit index = source code) is the last written enable bit i, forced to 1 for the source in use and for a switch target.
- R7: `sleep_req` while `switch_done` is high sets `in_sleep`. In sleep, `osc_en` equals the enable bits with every bit set in `sleep_stop` cleared.
- R8: With `wake_mode` at 0, `wake_evt` leaves sleep with the pre-sleep source and ratio. With `wake_osc_upd` also at 0, the pre-sleep `osc_en` is restored.
- R9: With `wake_mode` at 1 and `wake_src` from 0 to 2, `wake_evt` switches to `wake_src`/`wake_div`. The wakeup source's `osc_en` bit is high two cycles after the event. `cur_src`/`cur_div` show the wakeup pair when `switch_done` rises.
- R10: With `wake_osc_upd` at 1, the enable set after wakeup becomes `wake_osc_en`, with the bit of a valid wakeup source forced on.
- R11: With `wake_mode` at 1 and `wake_src` = 3, wakeup behaves as if `wake_mode` were 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on register/control clock |
| rst | input | 1 | Synchronous active-high reset (also clears the gate cells) |
| osc_clk | input | 4 | Oscillator clocks, bit index = source code |
| wr_en | input | 1 | One-cycle write strobe for the run configuration |
| wr_src | input | 2 | Source code to select |
| wr_div | input | 2 | Ratio code to select |
| wr_osc_en | input | 4 | Oscillator enable bits to store |
| sleep_req | input | 1 | Request to enter sleep |
| sleep_stop | input | 4 | Oscillators to stop during sleep |
| wake_evt | input | 1 | Wakeup event, ends sleep |
| wake_mode | input | 1 | 1 = load the wakeup source and ratio at exit |
| wake_src | input | 2 | Wakeup source code (0 to 2 valid) |
| wake_div | input | 2 | Wakeup ratio code |
| wake_osc_upd | input | 1 | 1 = replace the enable set at exit |
| wake_osc_en | input | 4 | Enable set used when `wake_osc_upd` is 1 |
| osc_en | output | 4 | Registered oscillator enable lines |
| sys_clk | output | 1 | Divided system clock |
| switch_done | output | 1 | High when no switch is running and not in sleep |
| in_sleep | output | 1 | High while in sleep |
| cur_src | output | 2 | Source code of the clock in use |
| cur_div | output | 2 | Ratio code in use |

## Verification
The hardest case to reach is a wakeup that switches away from a source the stop mask halted during sleep. Its gate flop is frozen high with no clock to release it, so the switch can finish only if the controller restarts that oscillator while the gate is taken down. The stimulus first puts the clock on the crystal source, then sleeps with a stop mask that covers exactly that source. It then wakes with wakeup mode set, an external-input target and a replacement enable set that leaves the crystal off. The resulting `sys_clk` period, `osc_en` pattern and reported fields are then measured.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DESEL = 3'd1,
    ST_GAP   = 3'd2,
    ST_SEL   = 3'd3,
    ST_SLEEP = 3'd4
  } ctl_state_e;
endpackage

// File: rtl/sysclk_sync2.sv
module sysclk_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sysclk_gate_cell.sv
module sysclk_gate_cell (
  input  logic src_clk,
  input  logic rst,
  input  logic sel,
  output logic gate,
  output logic clk_out
);
  logic meta;

  // Both stages on the falling edge so the gate only moves while src_clk is low.
  always_ff @(negedge src_clk or posedge rst) begin
    if (rst) begin
      meta <= 1'b0;
      gate <= 1'b0;
    end else begin
      meta <= sel;
      gate <= meta;
    end
  end

  assign clk_out = src_clk & gate;
endmodule

// File: rtl/sysclk_div.sv
module sysclk_div #(
  parameter int DIV_W = 2
) (
  input  logic             mux_clk,
  input  logic             clr,
  input  logic [DIV_W-1:0] ratio,
  output logic             sys_clk
);
  localparam int TAPS  = 1 << DIV_W;
  localparam int CNT_W = TAPS - 1;

  logic [CNT_W-1:0] cnt;
  logic [TAPS-1:0]  tap;

  always_ff @(posedge mux_clk or posedge clr) begin
    if (clr) cnt <= '0;
    else     cnt <= cnt + CNT_W'(1);
  end

  assign tap     = {cnt, mux_clk};
  assign sys_clk = tap[ratio];
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl #(
  parameter int SRC_W     = 2,
  parameter int DIV_W     = 2,
  parameter int BOOT_SRC  = 0,
  parameter int WAKE_SRCS = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [(1<<SRC_W)-1:0]  osc_clk,
  input  logic                   wr_en,
  input  logic [SRC_W-1:0]       wr_src,
  input  logic [DIV_W-1:0]       wr_div,
  input  logic [(1<<SRC_W)-1:0]  wr_osc_en,
  input  logic                   sleep_req,
  input  logic [(1<<SRC_W)-1:0]  sleep_stop,
  input  logic                   wake_evt,
  input  logic                   wake_mode,
  input  logic [SRC_W-1:0]       wake_src,
  input  logic [DIV_W-1:0]       wake_div,
  input  logic                   wake_osc_upd,
  input  logic [(1<<SRC_W)-1:0]  wake_osc_en,
  output logic [(1<<SRC_W)-1:0]  osc_en,
  output logic                   sys_clk,
  output logic                   switch_done,
  output logic                   in_sleep,
  output logic [SRC_W-1:0]       cur_src,
  output logic [DIV_W-1:0]       cur_div
);
  import sysclk_pkg::*;

  localparam int NSRC = 1 << SRC_W;
  localparam logic [SRC_W-1:0] BOOT     = SRC_W'(BOOT_SRC);
  localparam logic [SRC_W-1:0] WAKE_LIM = SRC_W'(WAKE_SRCS);

  function automatic logic [NSRC-1:0] oh(input logic [SRC_W-1:0] s);
    oh    = '0;
    oh[s] = 1'b1;
  endfunction

  ctl_state_e        state;
  logic [SRC_W-1:0]  tgt_src;
  logic [DIV_W-1:0]  tgt_div;
  logic [NSRC-1:0]   en_reg;
  logic [NSRC-1:0]   sel_q;
  logic [NSRC-1:0]   src_gate;
  logic [NSRC-1:0]   clk_g;
  logic [NSRC-1:0]   ack;
  logic              div_clr;
  logic              mux_clk;
  logic              wake_ok;
  logic [NSRC-1:0]   wake_base;
  logic [NSRC-1:0]   en_next;

  // One gate cell and one acknowledge synchroniser per source.
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    sysclk_gate_cell u_cell (
      .src_clk (osc_clk[g]),
      .rst     (rst),
      .sel     (sel_q[g]),
      .gate    (src_gate[g]),
      .clk_out (clk_g[g])
    );
    sysclk_sync2 u_ack (
      .clk (clk),
      .rst (rst),
      .d   (src_gate[g]),
      .q   (ack[g])
    );
  end

  assign mux_clk = |clk_g;

  sysclk_div #(.DIV_W(DIV_W)) u_div (
    .mux_clk (mux_clk),
    .clr     (div_clr | rst),
    .ratio   (cur_div),
    .sys_clk (sys_clk)
  );

  assign wake_ok   = wake_mode && (wake_src < WAKE_LIM);
  assign wake_base = wake_osc_upd ? wake_osc_en : en_reg;

  always_comb begin
    if (state == ST_SLEEP)
      en_next = en_reg & ~sleep_stop;
    else if (state == ST_IDLE)
      en_next = en_reg | oh(cur_src);
    else
      en_next = en_reg | oh(cur_src) | oh(tgt_src);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_SEL;
      tgt_src <= BOOT;
      tgt_div <= '0;
      cur_src <= BOOT;
      cur_div <= '0;
      en_reg  <= oh(BOOT);
      sel_q   <= oh(BOOT);
      div_clr <= 1'b0;
      osc_en  <= oh(BOOT);
    end else begin
      osc_en <= en_next;
      case (state)
        ST_IDLE: begin
          if (wr_en) begin
            en_reg <= wr_osc_en;
            if (wr_osc_en[wr_src] && ((wr_src != cur_src) || (wr_div != cur_div))) begin
              tgt_src <= wr_src;
              tgt_div <= wr_div;
              sel_q   <= '0;
              state   <= ST_DESEL;
            end
          end else if (sleep_req) begin
            state <= ST_SLEEP;
          end
        end
        ST_SLEEP: begin
          if (wake_evt) begin
            en_reg <= wake_base | (wake_ok ? oh(wake_src) : '0);
            if (wake_ok && ((wake_src != cur_src) || (wake_div != cur_div))) begin
              tgt_src <= wake_src;
              tgt_div <= wake_div;
              sel_q   <= '0;
              state   <= ST_DESEL;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_DESEL: begin
          if (ack == '0) begin
            div_clr <= 1'b1;
            state   <= ST_GAP;
          end
        end
        ST_GAP: begin
          cur_src <= tgt_src;
          cur_div <= tgt_div;
          div_clr <= 1'b0;
          sel_q   <= oh(tgt_src);
          state   <= ST_SEL;
        end
        ST_SEL: begin
          if (ack[cur_src]) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign switch_done = (state == ST_IDLE);
  assign in_sleep    = (state == ST_SLEEP);
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk #(
  parameter int SRC_W = 2,
  parameter int DIV_W = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [(1<<SRC_W)-1:0] src_gate,
  input logic [(1<<SRC_W)-1:0] osc_en,
  input logic                  switch_done,
  input logic                  in_sleep,
  input logic [SRC_W-1:0]      cur_src,
  input logic [DIV_W-1:0]      cur_div,
  input logic                  wr_en,
  input logic [SRC_W-1:0]      wr_src,
  input logic [(1<<SRC_W)-1:0] wr_osc_en,
  input logic                  wake_evt,
  input logic                  wake_mode,
  input logic [SRC_W-1:0]      wake_src,
  input logic [(1<<SRC_W)-1:0] sleep_stop
);
  AST_BOOT_STATE: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (cur_src == '0 && cur_div == '0 && osc_en == (1<<SRC_W)'(1))); // R1

  AST_ONE_GATE: assert property (@(posedge clk) disable iff (rst)
    $countones(src_gate) <= 1); // R4

  AST_DONE_GATED: assert property (@(posedge clk) disable iff (rst)
    switch_done |-> src_gate[cur_src]); // R2

  AST_REJECT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (switch_done && wr_en && !wr_osc_en[wr_src]) |=> (switch_done && $stable(cur_src) && $stable(cur_div))); // R5

  AST_SLEEP_STOP: assert property (@(posedge clk) disable iff (rst)
    (in_sleep && $past(in_sleep)) |-> ((osc_en & $past(sleep_stop)) == '0)); // R7

  AST_WAKE_FORCE: assert property (@(posedge clk) disable iff (rst)
    (in_sleep && wake_evt && wake_mode && wake_src < SRC_W'(3)) |-> ##2 osc_en[$past(wake_src, 2)]); // R9
endmodule

bind sysclk_ctrl sysclk_ctrl_chk #(.SRC_W(SRC_W), .DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .src_gate    (src_gate),
  .osc_en      (osc_en),
  .switch_done (switch_done),
  .in_sleep    (in_sleep),
  .cur_src     (cur_src),
  .cur_div     (cur_div),
  .wr_en       (wr_en),
  .wr_src      (wr_src),
  .wr_osc_en   (wr_osc_en),
  .wake_evt    (wake_evt),
  .wake_mode   (wake_mode),
  .wake_src    (wake_src),
  .sleep_stop  (sleep_stop)
);

// File: tb/sysclk_ctrl_bench.sv
`timescale 1ns/1ps
module sysclk_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] osc_clk;
  logic       wr_en = 1'b0;
  logic [1:0] wr_src = '0;
  logic [1:0] wr_div = '0;
  logic [3:0] wr_osc_en = '0;
  logic       sleep_req = 1'b0;
  logic [3:0] sleep_stop = '0;
  logic       wake_evt = 1'b0;
  logic       wake_mode = 1'b0;
  logic [1:0] wake_src = '0;
  logic [1:0] wake_div = '0;
  logic       wake_osc_upd = 1'b0;
  logic [3:0] wake_osc_en = '0;
  logic [3:0] osc_en;
  logic       sys_clk;
  logic       switch_done;
  logic       in_sleep;
  logic [1:0] cur_src;
  logic [1:0] cur_div;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  // Oscillator models: half periods 12, 8, 15, 31 ns; each toggles only while enabled.
  for (genvar g = 0; g < 4; g++) begin : g_osc
    logic c = 1'b0;
    localparam realtime HALF = (g == 0) ? 12.0 : (g == 1) ? 8.0 : (g == 2) ? 15.0 : 31.0;
    always begin
      if (osc_en[g] === 1'b1) begin
        #(HALF);
        if (osc_en[g] === 1'b1) c = ~c;
        else c = 1'b0;
      end else begin
        c = 1'b0;
        @(osc_en[g]);
      end
    end
    assign osc_clk[g] = c;
  end

  sysclk_ctrl u_sysclk_ctrl (
    .clk (clk), .rst (rst), .osc_clk (osc_clk),
    .wr_en (wr_en), .wr_src (wr_src), .wr_div (wr_div), .wr_osc_en (wr_osc_en),
    .sleep_req (sleep_req), .sleep_stop (sleep_stop), .wake_evt (wake_evt),
    .wake_mode (wake_mode), .wake_src (wake_src), .wake_div (wake_div),
    .wake_osc_upd (wake_osc_upd), .wake_osc_en (wake_osc_en),
    .osc_en (osc_en), .sys_clk (sys_clk), .switch_done (switch_done),
    .in_sleep (in_sleep), .cur_src (cur_src), .cur_div (cur_div)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic real src_period(input int s);
    case (s)
      0: return 24.0;
      1: return 16.0;
      2: return 30.0;
      default: return 62.0;
    endcase
  endfunction

  task automatic measure(input string req, input int s, input int d);
    realtime t0, t1;
    real exp_p;
    exp_p = src_period(s) * real'(1 << d);
    @(posedge sys_clk); t0 = $realtime;
    @(posedge sys_clk); t1 = $realtime;
    chk((t1 - t0) > exp_p - 0.01 && (t1 - t0) < exp_p + 0.01, req, int'(t1 - t0), int'(exp_p));
    @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] s, input logic [1:0] d, input logic [3:0] en);
    @(negedge clk);
    wr_src = s; wr_div = d; wr_osc_en = en; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    while (switch_done !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_sleep();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cur_src == 2'd0, "R1 cur_src after reset", cur_src, 0);
    chk(cur_div == 2'd0, "R1 cur_div after reset", cur_div, 0);
    chk(osc_en == 4'b0001, "R1 osc_en after reset", osc_en, 1);
    wait_done();
    measure("R1 boot period", 0, 0);
  endtask

  task automatic t_switch();
    do_write(2'd1, 2'd2, 4'b0011);
    chk(switch_done == 1'b0, "R2 done low during switch", switch_done, 0);
    wait_done();
    chk(cur_src == 2'd1 && cur_div == 2'd2, "R2 fields after switch", {cur_src, cur_div}, 6);
    measure("R3 R4 crystal div4 period", 1, 2);
    do_write(2'd2, 2'd3, 4'b0100);
    wait_done();
    chk(cur_src == 2'd2 && cur_div == 2'd3, "R2 fields ext div8", {cur_src, cur_div}, 11);
    chk(osc_en == 4'b0100, "R6 only ext enabled", osc_en, 4);
    measure("R3 ext div8 period", 2, 3);
  endtask

  task automatic t_reject();
    do_write(2'd3, 2'd0, 4'b0101);
    @(negedge clk);
    chk(switch_done == 1'b1, "R5 no switch started", switch_done, 1);
    chk(cur_src == 2'd2 && cur_div == 2'd3, "R5 fields kept", {cur_src, cur_div}, 11);
    chk(osc_en == 4'b0101, "R5 R6 enables still taken", osc_en, 5);
    measure("R5 period kept", 2, 3);
  endtask

  task automatic t_div1();
    do_write(2'd0, 2'd0, 4'b0001);
    wait_done();
    measure("R3 div1 period", 0, 0);
  endtask

  task automatic t_sleep_keep();
    do_write(2'd1, 2'd1, 4'b1011);
    wait_done();
    measure("R3 crystal div2 period", 1, 1);
    sleep_stop = 4'b1010; wake_mode = 1'b0; wake_osc_upd = 1'b0;
    pulse_sleep();
    chk(in_sleep == 1'b1, "R7 in_sleep set", in_sleep, 1);
    chk(osc_en == 4'b0001, "R7 stop mask applied", osc_en, 1);
    pulse_wake();
    chk(in_sleep == 1'b0 && switch_done == 1'b1, "R8 back to run", {in_sleep, switch_done}, 1);
    chk(cur_src == 2'd1 && cur_div == 2'd1, "R8 pre-sleep fields kept", {cur_src, cur_div}, 5);
    chk(osc_en == 4'b1011, "R8 enables restored", osc_en, 11);
    measure("R8 period kept", 1, 1);
  endtask

  task automatic t_wake_switch();
    sleep_stop = 4'b0010; wake_mode = 1'b1; wake_src = 2'd2; wake_div = 2'd1;
    wake_osc_upd = 1'b1; wake_osc_en = 4'b0001;
    pulse_sleep();
    chk(osc_en == 4'b1001, "R7 running source stopped", osc_en, 9);
    pulse_wake();
    wait_done();
    chk(cur_src == 2'd2 && cur_div == 2'd1, "R9 wake fields", {cur_src, cur_div}, 9);
    chk(osc_en == 4'b0101, "R10 R9 new enable set with wake source", osc_en, 5);
    measure("R9 wake period", 2, 1);
  endtask

  task automatic t_wake_reserved();
    sleep_stop = 4'b0000; wake_mode = 1'b1; wake_src = 2'd3; wake_div = 2'd3;
    wake_osc_upd = 1'b0;
    pulse_sleep();
    pulse_wake();
    chk(switch_done == 1'b1, "R11 no switch for code 3", switch_done, 1);
    chk(cur_src == 2'd2 && cur_div == 2'd1, "R11 fields kept", {cur_src, cur_div}, 9);
    measure("R11 period kept", 2, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_switch();
    t_reject();
    t_div1();
    t_sleep_keep();
    t_wake_switch();
    t_wake_reserved();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule